// File: doc/BRIEF.md
# Parallel EPROM Read Controller

This block sits on the synchronous side of a system and fetches single bytes from an external 64K x 8 one-time-programmable parallel memory. The memory has two active-low controls: a chip select, which takes it in and out of standby, and an output enable, which gates its data drivers. A host presents a 16-bit address with a valid/ready handshake. The controller then drives the address and pulls the chip select low. It asserts output enable as late as the memory allows without lengthening the access, and samples the byte once the access time in clock cycles has elapsed. It returns the byte with a one-cycle strobe and then releases output enable. Before it takes the next request it waits out the bus float time.

All memory delays are parameters in nanoseconds, two sets of them, one for the fast speed grade and one for the slow. Each is turned into a whole number of clock cycles, rounding up. A grade input selects the set, and its value is latched when a request is accepted. When the standby input is high, the chip select is raised once the controller is idle. When it is low, the memory stays selected between accesses.

Top module: `eprom_rd_ctrl`

## Requirements
- R1: While reset is held, and right after it is released, the outputs read mem_ce_n=1, mem_oe_n=1, busy=0, rd_valid=0, req_ready=1 and mem_addr=0.
- R2: When req_valid and req_ready are both high at a rising clock edge, the request is accepted at that edge. From that edge on, mem_addr carries req_addr, mem_ce_n is 0, busy is 1 and req_ready is 0.
- R3: With the fast grade at the default 10 ns clock (access 5, enable 5, output enable 2, float 2 cycles), mem_oe_n falls at the 3rd edge after the accept edge. It rises again at the 5th edge, which is max(access, chip-select) minus output-enable cycles after the accept edge for the fall, and the access length for the rise.
- R4: The byte on mem_dq is sampled at the edge that ends the access: the 5th edge after accept for the fast grade, the 7th for the slow. From that edge, rd_data holds the byte and rd_valid is 1 for exactly one cycle. Output enable is released at the same edge.
- R5: After output enable is released, busy stays 1 for the float cycle count (2 fast, 3 slow). req_ready then returns to 1. The next address change comes at least float+1 cycles after output enable rose.
- R6: slow_grade is sampled only at the accept edge. When it is 1, the access uses 7 access, 7 chip-select, 3 output-enable and 3 float cycles, so mem_oe_n falls at the 4th edge after accept. Changing slow_grade during an access has no effect on that access.
- R7: mem_oe_n is never 0 while mem_ce_n is 1.
- R8: When standby_en is 1 at an edge where the controller ends or stays idle without accepting, mem_ce_n becomes 1. When standby_en is 0, mem_ce_n stays 0 after an access.
- R9: A request presented while busy is not accepted: req_ready stays 0 and mem_addr keeps its value until the float interval ends. The held request is then taken.
- R10: mem_addr does not change from the accept edge until busy falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host read request |
| req_addr | input | 16 | Byte address of the request |
| slow_grade | input | 1 | 1 selects the slow timing set, latched at accept |
| standby_en | input | 1 | 1 lets the memory drop into standby when idle |
| mem_dq | input | 8 | Data lines from the memory |
| req_ready | output | 1 | Controller can accept a request this cycle |
| busy | output | 1 | From accept until the float interval completes |
| rd_valid | output | 1 | One-cycle strobe marking rd_data valid |
| rd_data | output | 8 | Last byte read |
| mem_addr | output | 16 | Address lines to the memory |
| mem_ce_n | output | 1 | Active-low chip select |
| mem_oe_n | output | 1 | Active-low output enable |

## Verification
The assertions assume the host holds req_valid and req_addr steady until the request is accepted. They also assume the memory drives valid data only once its access, select and enable delays are met. The gap check further takes the float count as at least one cycle. The bench drives every input at the falling clock edge and keeps each request up until it sees req_ready high. Its memory model returns the inverted byte whenever an address, select or enable age in cycles falls short of the latched grade's count. Any early sample therefore shows up as a data mismatch.

// File: rtl/eprom_rd_pkg.sv
package eprom_rd_pkg;

    localparam int CNT_W = 8;

    typedef logic [CNT_W-1:0] cyc_t;

    // Cycle counts of one speed grade
    typedef struct packed {
        cyc_t acc;
        cyc_t ce;
        cyc_t oe;
        cyc_t flt;
    } rd_timing_t;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACCESS = 2'd1,
        ST_FLOAT  = 2'd2
    } seq_state_t;

    // Round a delay up to whole clock periods
    function automatic int ns_to_cyc(int delay_ns, int period_ns);
        return (delay_ns + period_ns - 1) / period_ns;
    endfunction

endpackage

// File: rtl/eprom_timing_sel.sv
module eprom_timing_sel
    import eprom_rd_pkg::*;
#(
    parameter int CLK_NS      = 10,
    parameter int FAST_ACC_NS = 45,
    parameter int FAST_CE_NS  = 45,
    parameter int FAST_OE_NS  = 20,
    parameter int FAST_FLT_NS = 20,
    parameter int SLOW_ACC_NS = 70,
    parameter int SLOW_CE_NS  = 70,
    parameter int SLOW_OE_NS  = 30,
    parameter int SLOW_FLT_NS = 25
) (
    input  logic       slow,
    output rd_timing_t tm
);

    localparam int NGRADE = 2;

    rd_timing_t grade_tab [NGRADE];

    for (genvar g = 0; g < NGRADE; g++) begin : g_grade
        localparam int ACC_NS = (g == 0) ? FAST_ACC_NS : SLOW_ACC_NS;
        localparam int CE_NS  = (g == 0) ? FAST_CE_NS  : SLOW_CE_NS;
        localparam int OE_NS  = (g == 0) ? FAST_OE_NS  : SLOW_OE_NS;
        localparam int FLT_NS = (g == 0) ? FAST_FLT_NS : SLOW_FLT_NS;
        assign grade_tab[g].acc = CNT_W'(ns_to_cyc(ACC_NS, CLK_NS));
        assign grade_tab[g].ce  = CNT_W'(ns_to_cyc(CE_NS,  CLK_NS));
        assign grade_tab[g].oe  = CNT_W'(ns_to_cyc(OE_NS,  CLK_NS));
        assign grade_tab[g].flt = CNT_W'(ns_to_cyc(FLT_NS, CLK_NS));
    end

    assign tm = slow ? grade_tab[1] : grade_tab[0];

endmodule

// File: rtl/eprom_wait_cnt.sv
module eprom_wait_cnt
    import eprom_rd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output cyc_t cnt
);

    typedef struct packed {
        cyc_t cnt;
    } cnt_state_t;

    cnt_state_t q, d;

    always_comb begin
        d = q;
        if (restart) begin
            d.cnt = cyc_t'(1);
        end else if (q.cnt != '1) begin
            d.cnt = q.cnt + cyc_t'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign cnt = q.cnt;

endmodule

// File: rtl/eprom_rd_seq.sv
module eprom_rd_seq
    import eprom_rd_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              standby_en,
    input  rd_timing_t        tm_in,
    input  logic [DATA_W-1:0] mem_dq,
    input  cyc_t              cnt,
    output logic              restart,
    output logic              req_ready,
    output logic              busy,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_oe_n
);

    typedef struct packed {
        seq_state_t        st;
        logic [ADDR_W-1:0] addr;
        logic              ce_n;
        logic              oe_n;
        logic              busy;
        logic              valid;
        logic [DATA_W-1:0] data;
        rd_timing_t        tm;
        cyc_t              lead;
        cyc_t              oe_at;
    } seq_reg_t;

    seq_reg_t q, d;
    cyc_t     lead_w;
    cyc_t     oe_at_w;

    // Access length: chip-select delay only counts when leaving standby
    always_comb begin
        lead_w  = (q.ce_n && (tm_in.ce > tm_in.acc)) ? tm_in.ce : tm_in.acc;
        oe_at_w = (tm_in.oe >= lead_w) ? cyc_t'(0) : lead_w - tm_in.oe;
    end

    always_comb begin
        d       = q;
        d.valid = 1'b0;
        restart = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    d.st    = ST_ACCESS;
                    d.addr  = req_addr;
                    d.ce_n  = 1'b0;
                    d.busy  = 1'b1;
                    d.tm    = tm_in;
                    d.lead  = lead_w;
                    d.oe_at = oe_at_w;
                    d.oe_n  = (oe_at_w != cyc_t'(0));
                    restart = 1'b1;
                end else if (standby_en) begin
                    d.ce_n = 1'b1;
                end
            end
            ST_ACCESS: begin
                if (cnt == q.oe_at) begin
                    d.oe_n = 1'b0;
                end
                if (cnt >= q.lead) begin
                    d.data  = mem_dq;
                    d.valid = 1'b1;
                    d.oe_n  = 1'b1;
                    d.st    = ST_FLOAT;
                    restart = 1'b1;
                end
            end
            ST_FLOAT: begin
                if (cnt >= q.tm.flt) begin
                    d.st   = ST_IDLE;
                    d.busy = 1'b0;
                    if (standby_en) begin
                        d.ce_n = 1'b1;
                    end
                end
            end
            default: begin
                d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= ST_IDLE;
            q.ce_n <= 1'b1;
            q.oe_n <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign req_ready = (q.st == ST_IDLE);
    assign busy      = q.busy;
    assign rd_valid  = q.valid;
    assign rd_data   = q.data;
    assign mem_addr  = q.addr;
    assign mem_ce_n  = q.ce_n;
    assign mem_oe_n  = q.oe_n;

    // Checker state: cycles since output enable was last released
    cyc_t gap_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q <= '1;
        end else if (!q.oe_n) begin
            gap_q <= '0;
        end else if (gap_q != '1) begin
            gap_q <= gap_q + cyc_t'(1);
        end
    end

    p_float_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && req_valid) |-> (gap_q >= q.tm.flt));

    p_oe_needs_ce_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> !mem_ce_n);

    p_valid_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    p_valid_released_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (mem_oe_n && busy));

    p_addr_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(mem_addr));

    p_hold_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && req_valid) |=> (mem_addr == $past(mem_addr)));

endmodule

// File: rtl/eprom_rd_ctrl.sv
module eprom_rd_ctrl
    import eprom_rd_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int DATA_W      = 8,
    parameter int CLK_NS      = 10,
    parameter int FAST_ACC_NS = 45,
    parameter int FAST_CE_NS  = 45,
    parameter int FAST_OE_NS  = 20,
    parameter int FAST_FLT_NS = 20,
    parameter int SLOW_ACC_NS = 70,
    parameter int SLOW_CE_NS  = 70,
    parameter int SLOW_OE_NS  = 30,
    parameter int SLOW_FLT_NS = 25
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              slow_grade,
    input  logic              standby_en,
    input  logic [DATA_W-1:0] mem_dq,
    output logic              req_ready,
    output logic              busy,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_oe_n
);

    rd_timing_t tm_sel;
    cyc_t       wait_cnt;
    logic       cnt_restart;

    eprom_timing_sel #(
        .CLK_NS      (CLK_NS),
        .FAST_ACC_NS (FAST_ACC_NS),
        .FAST_CE_NS  (FAST_CE_NS),
        .FAST_OE_NS  (FAST_OE_NS),
        .FAST_FLT_NS (FAST_FLT_NS),
        .SLOW_ACC_NS (SLOW_ACC_NS),
        .SLOW_CE_NS  (SLOW_CE_NS),
        .SLOW_OE_NS  (SLOW_OE_NS),
        .SLOW_FLT_NS (SLOW_FLT_NS)
    ) u_tsel (
        .slow (slow_grade),
        .tm   (tm_sel)
    );

    eprom_wait_cnt u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (cnt_restart),
        .cnt     (wait_cnt)
    );

    eprom_rd_seq #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_addr   (req_addr),
        .standby_en (standby_en),
        .tm_in      (tm_sel),
        .mem_dq     (mem_dq),
        .cnt        (wait_cnt),
        .restart    (cnt_restart),
        .req_ready  (req_ready),
        .busy       (busy),
        .rd_valid   (rd_valid),
        .rd_data    (rd_data),
        .mem_addr   (mem_addr),
        .mem_ce_n   (mem_ce_n),
        .mem_oe_n   (mem_oe_n)
    );

endmodule

// File: tb/eprom_rd_ctrl_tb.sv
module eprom_rd_ctrl_tb;

    localparam int CLK_NS = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic [15:0] req_addr;
    logic        slow_grade;
    logic        standby_en;
    logic [7:0]  mem_dq;
    logic        req_ready;
    logic        busy;
    logic        rd_valid;
    logic [7:0]  rd_data;
    logic [15:0] mem_addr;
    logic        mem_ce_n;
    logic        mem_oe_n;

    always #(CLK_NS/2) clk = ~clk;

    eprom_rd_ctrl u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_addr   (req_addr),
        .slow_grade (slow_grade),
        .standby_en (standby_en),
        .mem_dq     (mem_dq),
        .req_ready  (req_ready),
        .busy       (busy),
        .rd_valid   (rd_valid),
        .rd_data    (rd_data),
        .mem_addr   (mem_addr),
        .mem_ce_n   (mem_ce_n),
        .mem_oe_n   (mem_oe_n)
    );

    function automatic int to_cyc(int dly);
        return (dly + CLK_NS - 1) / CLK_NS;
    endfunction

    function automatic logic [7:0] mem_byte(logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction

    int checks   = 0;
    int failures = 0;
    bit done     = 0;

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Reference model state
    int          now_e  = 0;
    int          t0     = -100000;
    int          m_lead = 5;
    int          m_df   = 2;
    int          m_acc  = 5;
    int          m_ce   = 5;
    int          m_oe   = 2;
    bit          m_slow = 0;
    bit          m_ce_n = 1;
    logic [15:0] m_addr = '0;
    logic [7:0]  m_data = '0;

    function automatic bit busy_after(int e);
        return (e - t0) >= 0 && (e - t0) < (m_lead + m_df);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            t0 = -100000; m_ce_n = 1; m_addr = '0; m_data = '0;
        end else if (req_valid && !busy_after(now_e - 1)) begin
            m_slow = slow_grade;
            m_acc  = to_cyc(slow_grade ? 70 : 45);
            m_ce   = to_cyc(slow_grade ? 70 : 45);
            m_oe   = to_cyc(slow_grade ? 30 : 20);
            m_df   = to_cyc(slow_grade ? 25 : 20);
            m_lead = (m_ce_n && m_ce > m_acc) ? m_ce : m_acc;
            m_ce_n = 0;
            m_addr = req_addr;
            t0     = now_e;
        end else begin
            if ((now_e - t0) == m_lead) m_data = mem_byte(m_addr);
            if (!busy_after(now_e) && standby_en) m_ce_n = 1;
        end
        now_e++;
    end

    // Memory model: ages in cycles of address, select and enable
    int          addr_age = 0;
    int          oe_age   = 0;
    int          ce_age   = 0;
    logic [15:0] prev_addr = '0;

    assign mem_dq = (!mem_ce_n && !mem_oe_n && addr_age >= m_acc &&
                     oe_age >= m_oe && ce_age >= m_ce)
                    ? mem_byte(mem_addr) : ~mem_byte(mem_addr);

    always @(negedge clk) begin
        int k;
        addr_age  = (mem_addr != prev_addr) ? 1 : addr_age + 1;
        prev_addr = mem_addr;
        oe_age    = mem_oe_n ? 0 : oe_age + 1;
        ce_age    = mem_ce_n ? 0 : ce_age + 1;
        if (addr_age > 1000) addr_age = 1000;
        if (ce_age > 1000) ce_age = 1000;
        k = (now_e - 1) - t0;
        if (!rst_n) begin
            chk("R1", "ce_n in reset", mem_ce_n, 1);
            chk("R1", "oe_n in reset", mem_oe_n, 1);
            chk("R1", "busy in reset", busy, 0);
            chk("R1", "rd_valid in reset", rd_valid, 0);
            chk("R1", "ready in reset", req_ready, 1);
            chk("R1", "addr in reset", mem_addr, 0);
        end else if (now_e > 0) begin
            bit eb;
            eb = (k >= 0) && (k < m_lead + m_df);
            chk("R5", "busy", busy, eb);
            chk((req_valid && eb) ? "R9" : "R5", "req_ready", req_ready, !eb);
            chk(m_slow ? "R6" : "R3", "oe_n", mem_oe_n,
                !((k >= m_lead - m_oe) && (k < m_lead)));
            chk("R4", "rd_valid", rd_valid, (k == m_lead));
            if (rd_valid) chk(m_slow ? "R6" : "R4", "rd_data", rd_data, m_data);
            chk(eb ? "R10" : "R2", "mem_addr", mem_addr, m_addr);
            chk("R8", "ce_n", mem_ce_n, m_ce_n);
            chk("R7", "oe low with ce high", (!mem_oe_n && mem_ce_n), 0);
        end
    end

    task automatic do_read(logic [15:0] a, bit slow);
        bit r;
        @(negedge clk);
        req_valid  = 1;
        req_addr   = a;
        slow_grade = slow;
        do begin
            r = req_ready;
            @(negedge clk);
        end while (!r);
        req_valid = 0;
    endtask

    initial begin
        rst_n = 0; req_valid = 0; req_addr = '0; slow_grade = 0; standby_en = 1;
        repeat (3) @(negedge clk);
        rst_n = 1;
        repeat (2) @(negedge clk);
        // fast grade, standby between accesses
        do_read(16'h1234, 0);
        repeat (8) @(negedge clk);
        do_read(16'hABCD, 0);
        do_read(16'h0F0F, 0);   // held off while busy (R9)
        do_read(16'hFFFF, 0);
        repeat (8) @(negedge clk);
        // slow grade, then grade flips mid-access
        do_read(16'h8001, 1);
        slow_grade = 0;
        repeat (10) @(negedge clk);
        do_read(16'h4242, 1);
        do_read(16'h0001, 0);
        // memory kept selected
        standby_en = 0;
        repeat (10) @(negedge clk);
        do_read(16'h7E7E, 0);
        do_read(16'hC3C3, 1);
        repeat (12) @(negedge clk);
        do_read(16'h5555, 0);
        repeat (12) @(negedge clk);
        standby_en = 1;
        repeat (6) @(negedge clk);
        do_read(16'h2AAA, 1);
        repeat (15) @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL R5 watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule